// File: doc/BRIEF.md
# Quarter-Wave Bitstream Sine Sequencer

This block drives one three-state pin with a pulse-density bitstream. The local density of driven samples rises and falls sinusoidally, so an external RC integrator, or two in series, can smooth the pin into a sine. A parameter holds only one quarter of the wave as one bit per sample. The block unfolds that quarter into a full cycle. It reads the quarter forward, then backward, and repeats that pair with the drive polarity inverted.

The wave is divided into sample slots. Every slot starts with a pulse phase that has a fixed width in clocks. A dead phase follows, and its length comes from a 16-bit dead-time input. The pulse energy per sample stays the same, so the output frequency is lowered by adding dead time and not by widening pulses. A cycle-start strobe marks the first sample of each wave, which lets the output be lined up with the pattern.

The block has no data stream, so it has no valid/ready handshake. All pins are plain control and status signals.

Top module: `bitsine_seq`

## Requirements
- R1: While `rst_n` is low, and in any cycle where `enable` is low, `pin_oe`, `pin_out` and `cycle_start` are all 0.
- R2: Each sample slot is a pulse phase of exactly `PULSE_W` clocks, followed by a dead phase of D clocks. D is the slot's latched dead time and may be 0. `pin_oe` can be 1 only during the pulse phase.
- R3: `dead_time` is sampled on the clock edge that begins a slot. A change made at any other time affects only the next slot and never shortens or lengthens the current pulse.
- R4: Sample n of the wave runs from 0 to 4·QLEN−1. Its quadrant is q = n / QLEN and its position is i = n mod QLEN. The selected bit is `PATTERN[i]` when q is even and `PATTERN[QLEN-1-i]` when q is odd.
- R5: During the pulse phase, `pin_oe` equals the selected bit: 1 means drive the pin and 0 means float it.
- R6: While `pin_oe` is 1, `pin_out` is 1 in quadrants 0 and 1 and 0 in quadrants 2 and 3. `pin_out` is 0 whenever `pin_oe` is 0.
- R7: `cycle_start` is 1 only during the first clock of the pulse phase of sample 0, and only with high drive polarity.
- R8: If `enable` is sampled high while the block is idle, the pulse phase of sample 0 begins on the next clock. Lowering `enable` clears `pin_oe` in the same cycle, and the next enable restarts the wave at sample 0.
- R9: After sample 4·QLEN−1 the sequence wraps to sample 0 and continues without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer; low forces idle |
| dead_time | input | 16 | Dead clocks appended after each pulse |
| pin_oe | output | 1 | Pin output enable (1 = driven) |
| pin_out | output | 1 | Pin drive level when enabled |
| cycle_start | output | 1 | One-clock strobe at the first sample of the wave |

## Verification
The bench builds the block with QLEN = 6, PULSE_W = 2 and the 6-bit pattern 6'b111010. With these values a whole wave is only 24 samples, so every quadrant turn, both polarities and the wrap back to sample 0 occur several times within a few hundred clocks. Under that configuration the bench sweeps dead times of 0, 1, 3 and 5, and it changes the dead time partway through a pulse. Every cycle it compares all three outputs against an arithmetic slot, quadrant and index model.

// File: rtl/bitsine_pkg.sv
package bitsine_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULSE = 2'd1,
    PH_DEAD  = 2'd2
  } phase_t;
endpackage

// File: rtl/bitsine_slot_timer.sv
module bitsine_slot_timer
  import bitsine_pkg::*;
#(
  parameter int PULSE_W = 4,
  parameter int DT_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DT_W-1:0] dead_time,
  output logic            in_pulse,
  output logic            slot_start,
  output logic            slot_last
);
  localparam int PWB = $clog2(PULSE_W + 1);
  localparam int CW  = (DT_W > PWB) ? DT_W : PWB;

  phase_t          phase_q;
  logic [CW-1:0]   cnt_q;
  logic [DT_W-1:0] dt_q;
  logic            pulse_end;
  logic            dead_end;

  assign pulse_end  = (phase_q == PH_PULSE) && (cnt_q == CW'(PULSE_W - 1));
  assign dead_end   = (phase_q == PH_DEAD) && (cnt_q == CW'(dt_q) - CW'(1));
  assign slot_last  = (pulse_end && (dt_q == '0)) || dead_end;
  assign in_pulse   = (phase_q == PH_PULSE);
  assign slot_start = in_pulse && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dt_q    <= '0;
    end else if (!run) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_PULSE;
          cnt_q   <= '0;
          dt_q    <= dead_time;
        end
        PH_PULSE: begin
          if (pulse_end) begin
            cnt_q <= '0;
            if (dt_q == '0) dt_q <= dead_time;
            else            phase_q <= PH_DEAD;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_DEAD: begin
          if (dead_end) begin
            phase_q <= PH_PULSE;
            cnt_q   <= '0;
            dt_q    <= dead_time;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitsine_quad_index.sv
module bitsine_quad_index #(
  parameter int QLEN = 54,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic [1:0]    quad
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      quad <= '0;
    end else if (!run) begin
      idx  <= '0;
      quad <= '0;
    end else if (advance) begin
      if (idx == IW'(QLEN - 1)) begin
        idx  <= '0;
        quad <= quad + 2'd1;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/bitsine_seq.sv
module bitsine_seq #(
  parameter int              QLEN    = 54,
  parameter int              PULSE_W = 4,
  parameter logic [QLEN-1:0] PATTERN = 54'h3FFF_DDB6_A524_88
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [15:0] dead_time,
  output logic        pin_oe,
  output logic        pin_out,
  output logic        cycle_start
);
  localparam int DT_W = 16;
  localparam int IW   = (QLEN > 1) ? $clog2(QLEN) : 1;

  logic          in_pulse;
  logic          slot_start;
  logic          slot_last;
  logic [IW-1:0] idx;
  logic [1:0]    quad;
  logic [IW-1:0] rd_idx;
  logic          sel_bit;
  logic          drive_hi;

  bitsine_slot_timer #(.PULSE_W(PULSE_W), .DT_W(DT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .dead_time(dead_time),
    .in_pulse(in_pulse), .slot_start(slot_start), .slot_last(slot_last)
  );

  bitsine_quad_index #(.QLEN(QLEN), .IW(IW)) index_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .advance(slot_last),
    .idx(idx), .quad(quad)
  );

  // Odd quadrants read the quarter table backward.
  assign rd_idx   = quad[0] ? (IW'(QLEN - 1) - idx) : idx;
  assign sel_bit  = PATTERN[rd_idx];
  assign drive_hi = ~quad[1];

  assign pin_oe      = enable & in_pulse & sel_bit;
  assign pin_out     = pin_oe & drive_hi;
  assign cycle_start = enable & slot_start & (quad == 2'd0) & (idx == '0);
endmodule

// File: rtl/bitsine_seq_chk.sv
module bitsine_seq_chk #(
  parameter int PULSE_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic pin_oe,
  input logic pin_out,
  input logic cycle_start,
  input logic in_pulse,
  input logic slot_start,
  input logic drive_hi
);
  logic [15:0] age_q;
  logic [15:0] age_w;

  assign age_w = slot_start ? 16'd0 : age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= 16'd0;
    else if (age_w != 16'hFFFF) age_q <= age_w + 16'd1;
    else                       age_q <= age_w;
  end

  p_float_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  p_oe_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (enable && in_pulse));

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (age_w < 16'(PULSE_W)));

  p_start_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (slot_start && drive_hi));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pin_oe && !cycle_start));
endmodule

bind bitsine_seq bitsine_seq_chk #(.PULSE_W(PULSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pin_oe(pin_oe),
  .pin_out(pin_out), .cycle_start(cycle_start), .in_pulse(in_pulse),
  .slot_start(slot_start), .drive_hi(drive_hi)
);

// File: tb/bitsine_seq_tb.sv
module bitsine_seq_tb_top;
  localparam int             Q   = 6;
  localparam int             PW  = 2;
  localparam logic [Q-1:0]   PAT = 6'b111010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [15:0] dead_time = 16'd0;
  logic pin_oe, pin_out, cycle_start;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state
  int off, ns, cur_d, dt_seen;

  always #4 clk = ~clk;

  bitsine_seq #(.QLEN(Q), .PULSE_W(PW), .PATTERN(PAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dead_time(dead_time),
    .pin_oe(pin_oe), .pin_out(pin_out), .cycle_start(cycle_start)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string what, input logic got, input logic exp);
    n_vec = n_vec + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", what, got, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " oe"}, pin_oe, 1'b0);
    check({tag, " out"}, pin_out, 1'b0);
    check({tag, " cs"}, cycle_start, 1'b0);
  endtask

  // Raise enable at a negedge with dead time d; the model starts at sample 0.
  task automatic start_run(input int d);
    @(negedge clk);
    dead_time = 16'(d);
    enable = 1'b1;
    dt_seen = d;
    off = 0;
    ns = 0;
  endtask

  // Run n cycles; at cycle chg_at (if >= 0) change dead time to chg_val.
  task automatic run_cycles(input int n, input int chg_at, input int chg_val);
    for (int k = 0; k < n; k++) begin
      int q, i;
      logic b, eoe, eout, ecs;
      @(negedge clk);
      if (off == 0) cur_d = dt_seen;            // R3 latch at slot start
      q = ns / Q;
      i = ns % Q;
      b = (q % 2 == 1) ? PAT[Q-1-i] : PAT[i];   // R4 unfolding
      eoe = (off < PW) && b;                    // R2 R5
      eout = eoe && (q < 2);                    // R6
      ecs = (off == 0) && (ns == 0);            // R7 R8
      check("R5 pin_oe (R2 R3 R4 R9)", pin_oe, eoe);
      check("R6 pin_out", pin_out, eout);
      check("R7 cycle_start", cycle_start, ecs);
      off = off + 1;
      if (off == PW + cur_d) begin
        off = 0;
        ns = (ns + 1) % (4 * Q);                // R9 wrap
      end
      if (k == chg_at) dead_time = 16'(chg_val);
      dt_seen = int'(dead_time);
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    #1;
    check("R8 oe drops with enable", pin_oe, 1'b0);
    check("R8 out drops with enable", pin_out, 1'b0);
    @(negedge clk);
    check_idle("R1 idle after disable");
  endtask

  initial begin
    int dts[4] = '{0, 1, 3, 5};
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_idle("R1 enable low");
    end

    foreach (dts[j]) begin
      start_run(dts[j]);
      run_cycles(2 * 4 * Q * (PW + dts[j]) + 7, -1, 0);
      stop_run();
    end

    // Dead time changed mid-pulse, then to zero (R3).
    start_run(2);
    run_cycles(150, 4, 4);
    run_cycles(150, 0, 0);
    run_cycles(60, 10, 3);
    stop_run();

    // Disable mid-wave and restart from sample 0 (R8).
    start_run(1);
    run_cycles(37, -1, 0);
    stop_run();
    start_run(1);
    run_cycles(80, -1, 0);
    stop_run();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule